// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps the results of an out-of-order core in program order. When an instruction issues, it claims the slot at the tail of a circular buffer. It gets back the slot number as its producer tag, and the slot records the destination register. When a functional unit finishes, it writes the result word and its exception flags into the slot named by the tag, and the slot becomes valid. Issue logic can read any slot's valid bit and result through two independent combinational ports to pick up operands that are already complete.

Every cycle the oldest slot, the head, is examined. Once it is valid, its exception flags are gated by the status-register enable bits, and one flag is always enabled regardless of the mask.

- **No enabled flag:** the head commits. It drives a register-file write if it has a destination, and the head moves on.
- **Enabled flag present:** the lowest-numbered enabled flag selects an interrupt type.
  - **Continue:** the result is still written, the head advances, and an interrupt request is raised.
  - **Repeat or abort:** nothing is written, an interrupt request is raised, and the whole buffer is discarded.

Top module: `rob_precise_commit`

## Requirements
- R1: After reset the buffer is empty: `issue_ready` is 1, `issue_tag` is 0, and `rf_we`, `irq_valid` and `flush` are 0.
- R2: `issue_tag` shows the tail slot number combinationally. A granted issue (`issue_valid` and `issue_ready`) stores the destination and its has-destination bit in that slot, and the tail increments modulo 8 at the clock edge.
- R3: With 8 slots allocated and not yet retired, `issue_ready` is 0 and an issue request changes neither the tail nor any slot. Retiring one slot raises `issue_ready` again.
- R4: A completion writes data and flags into the tagged slot and marks it valid at the clock edge, but only if that slot is allocated. A completion to a free slot is ignored.
- R5: Only the head slot commits. While the head is not valid nothing is written, even when younger slots are complete. When the head is valid, `rf_we`, `rf_addr` and `rf_data` show its commit in the same cycle, and the head advances at the next edge.
- R6: A slot issued without a destination retires without asserting `rf_we`.
- R7: Flag k is enabled when `sr_mask[k]` is 1. Flag 0 is enabled regardless of the mask. Flags that are not enabled have no effect, and the head commits cleanly.
- R8: The lowest-numbered enabled flag sets `irq_kind`: flag 0 gives abort (2'b10), flag 1 gives repeat (2'b01), and flags 2 and 3 give continue (2'b00). `irq_flags` carries all enabled flags. When `irq_valid` is 0, both `irq_kind` and `irq_flags` are 0.
- R9: For a continue interrupt, the result is written to the register file in the same cycle as `irq_valid`, the head advances, and `flush` stays 0.
- R10: For an abort or repeat interrupt, `rf_we` is 0 and `flush` is 1 in that cycle. At the next edge every slot becomes free and invalid, and the tail returns to the head.
- R11: Two read ports each return the valid bit and data of the slot named by their own tag, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Request to allocate the tail slot |
| issue_has_dest | input | 1 | Issuing instruction writes a register |
| issue_dest | input | 4 | Destination register address |
| issue_ready | output | 1 | Allocation possible this cycle |
| issue_tag | output | 3 | Slot number handed to the issuing instruction |
| cpl_valid | input | 1 | A result is being returned |
| cpl_tag | input | 3 | Slot the result belongs to |
| cpl_data | input | 64 | Result word |
| cpl_flags | input | 4 | Exception flags of the result |
| sr_mask | input | 4 | Status-register exception enables |
| rd_tag_a | input | 3 | Operand read port A slot |
| rd_valid_a | output | 1 | Slot A holds a completed result |
| rd_data_a | output | 64 | Slot A result |
| rd_tag_b | input | 3 | Operand read port B slot |
| rd_valid_b | output | 1 | Slot B holds a completed result |
| rd_data_b | output | 64 | Slot B result |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 4 | Register-file write address |
| rf_data | output | 64 | Register-file write data |
| irq_valid | output | 1 | Interrupt request from the head slot |
| irq_kind | output | 2 | 00 continue, 01 repeat, 10 abort |
| irq_flags | output | 4 | Enabled flags of the head slot |
| flush | output | 1 | Buffer discarded at the next edge |

## Verification
`issue_tag`, the read ports and all commit outputs are combinational from stored state. A completion therefore shows up on the read ports, and on `rf_we`/`irq_valid`/`flush` if it hits the head, just after the edge that captured it. The retirement or flush then takes effect at the following edge. The bench drives inputs on the falling edge or shortly after a rising edge, and reads the commit outputs in the gap before the next rising edge, because that edge already consumes the head. Effects on the head and tail are checked one edge later, through `issue_tag`, `issue_ready` and the read ports.

// File: rtl/rob_pkg.sv
// Shared encodings for the reorder buffer.
// Assumes: interrupt type codes are decoded by the interrupt controller.
package rob_pkg;
    typedef enum logic [1:0] {
        IRQ_CONTINUE = 2'b00,
        IRQ_REPEAT   = 2'b01,
        IRQ_ABORT    = 2'b10
    } irq_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
// Head/tail/occupancy bookkeeping for the circular buffer.
// Assumes DEPTH is a power of two so pointers wrap naturally.
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             retire,
    input  logic             flush,
    output logic             alloc,
    output logic             full,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count
);
    assign full  = (count == CNT_W'(DEPTH));
    assign alloc = alloc_req && !full && !flush;

    // Advance pointers; a flush pulls the tail back to the head and empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            tail  <= head;
            count <= '0;
        end else begin
            if (retire) head <= head + TAG_W'(1);
            if (alloc)  tail <= tail + TAG_W'(1);
            count <= count + CNT_W'(alloc) - CNT_W'(retire);
        end
    end
endmodule

// File: rtl/rob_entry_store.sv
// Slot storage: each slot keeps busy/valid state, destination, result, flags.
// Assumes at most one allocation, one completion and one retirement per cycle.
module rob_entry_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 4,
    parameter int FLAG_W = 4,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [TAG_W-1:0]  tail,
    input  logic              alloc_has_dest,
    input  logic [ADDR_W-1:0] alloc_dest,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic [FLAG_W-1:0] cpl_flags,
    input  logic              retire,
    input  logic              flush,
    input  logic [TAG_W-1:0]  head,
    input  logic [TAG_W-1:0]  rd_tag_a,
    input  logic [TAG_W-1:0]  rd_tag_b,
    output logic              head_vld,
    output logic              head_has_dest,
    output logic [ADDR_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_data,
    output logic [FLAG_W-1:0] head_flags,
    output logic              rd_vld_a,
    output logic [DATA_W-1:0] rd_data_a,
    output logic              rd_vld_b,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DEPTH-1:0]  vld_v;
    logic [DEPTH-1:0]  hasd_v;
    logic [ADDR_W-1:0] dest_a  [DEPTH];
    logic [DATA_W-1:0] data_a  [DEPTH];
    logic [FLAG_W-1:0] flags_a [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              busy_q;
        logic              vld_q;
        logic              hasd_q;
        logic [ADDR_W-1:0] dest_q;
        logic [DATA_W-1:0] data_q;
        logic [FLAG_W-1:0] flags_q;

        // Slot lifecycle: claim at issue, fill at completion, free at retire/flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q  <= 1'b0;
                vld_q   <= 1'b0;
                hasd_q  <= 1'b0;
                dest_q  <= '0;
                data_q  <= '0;
                flags_q <= '0;
            end else if (flush) begin
                busy_q <= 1'b0;
                vld_q  <= 1'b0;
            end else begin
                if (alloc && tail == TAG_W'(i)) begin
                    busy_q <= 1'b1;
                    vld_q  <= 1'b0;
                    hasd_q <= alloc_has_dest;
                    dest_q <= alloc_dest;
                end
                if (cpl_valid && cpl_tag == TAG_W'(i) && busy_q) begin
                    vld_q   <= 1'b1;
                    data_q  <= cpl_data;
                    flags_q <= cpl_flags;
                end
                if (retire && head == TAG_W'(i)) begin
                    busy_q <= 1'b0;
                    vld_q  <= 1'b0;
                end
            end
        end

        assign vld_v[i]   = vld_q;
        assign hasd_v[i]  = hasd_q;
        assign dest_a[i]  = dest_q;
        assign data_a[i]  = data_q;
        assign flags_a[i] = flags_q;
    end

    assign head_vld      = vld_v[head];
    assign head_has_dest = hasd_v[head];
    assign head_dest     = dest_a[head];
    assign head_data     = data_a[head];
    assign head_flags    = flags_a[head];

    assign rd_vld_a  = vld_v[rd_tag_a];
    assign rd_data_a = data_a[rd_tag_a];
    assign rd_vld_b  = vld_v[rd_tag_b];
    assign rd_data_b = data_a[rd_tag_b];
endmodule

// File: rtl/rob_commit_logic.sv
// Head commit decision: masks flags, picks the interrupt type by flag priority,
// and chooses between plain commit, commit-with-interrupt and flush.
// Assumes KIND_MAP holds 2 bits per flag, flag 0 in the lowest pair.
module rob_commit_logic #(
    parameter int                  DATA_W     = 64,
    parameter int                  ADDR_W     = 4,
    parameter int                  FLAG_W     = 4,
    parameter logic [2*FLAG_W-1:0] KIND_MAP   = 8'b0000_0110,
    parameter logic [FLAG_W-1:0]   FORCE_MASK = 4'b0001
) (
    input  logic              head_vld,
    input  logic              head_has_dest,
    input  logic [ADDR_W-1:0] head_dest,
    input  logic [DATA_W-1:0] head_data,
    input  logic [FLAG_W-1:0] head_flags,
    input  logic [FLAG_W-1:0] sr_mask,
    output logic              retire,
    output logic              flush,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_data,
    output logic              irq_valid,
    output logic [1:0]        irq_kind,
    output logic [FLAG_W-1:0] irq_flags
);
    import rob_pkg::*;

    logic [FLAG_W-1:0] enabled;
    logic [1:0]        sel_kind;
    logic              found;

    // Gate flags and find the lowest-numbered enabled one.
    always_comb begin
        enabled  = head_flags & (sr_mask | FORCE_MASK);
        sel_kind = IRQ_CONTINUE;
        found    = 1'b0;
        for (int k = 0; k < FLAG_W; k++) begin
            if (!found && enabled[k]) begin
                sel_kind = KIND_MAP[2*k +: 2];
                found    = 1'b1;
            end
        end
    end

    // Resolve the head's fate this cycle.
    always_comb begin
        irq_valid = head_vld && found;
        flush     = irq_valid && (sel_kind != IRQ_CONTINUE);
        retire    = head_vld && !flush;
        rf_we     = retire && head_has_dest;
        rf_addr   = head_dest;
        rf_data   = head_data;
        irq_kind  = irq_valid ? sel_kind : IRQ_CONTINUE;
        irq_flags = irq_valid ? enabled : '0;
    end
endmodule

// File: rtl/rob_precise_commit.sv
// Reorder buffer top: allocation at the tail, tagged completion, two operand
// read ports, and in-order commit with masked exception checking at the head.
// Assumes the register file and interrupt handler sit outside this block.
module rob_precise_commit #(
    parameter int                  DEPTH      = 8,
    parameter int                  DATA_W     = 64,
    parameter int                  ADDR_W     = 4,
    parameter int                  FLAG_W     = 4,
    parameter logic [2*FLAG_W-1:0] KIND_MAP   = 8'b0000_0110,
    parameter logic [FLAG_W-1:0]   FORCE_MASK = 4'b0001,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = TAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_has_dest,
    input  logic [ADDR_W-1:0] issue_dest,
    output logic              issue_ready,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic [FLAG_W-1:0] cpl_flags,
    input  logic [FLAG_W-1:0] sr_mask,
    input  logic [TAG_W-1:0]  rd_tag_a,
    output logic              rd_valid_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [TAG_W-1:0]  rd_tag_b,
    output logic              rd_valid_b,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_data,
    output logic              irq_valid,
    output logic [1:0]        irq_kind,
    output logic [FLAG_W-1:0] irq_flags,
    output logic              flush
);
    logic              alloc_w;
    logic              full_w;
    logic              retire_w;
    logic [TAG_W-1:0]  head_w;
    logic [TAG_W-1:0]  tail_w;
    logic [CNT_W-1:0]  occ;
    logic              head_vld;
    logic              head_hasd;
    logic [ADDR_W-1:0] head_dest;
    logic [DATA_W-1:0] head_data;
    logic [FLAG_W-1:0] head_flags;

    assign issue_ready = !full_w && !flush;
    assign issue_tag   = tail_w;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (issue_valid),
        .retire    (retire_w),
        .flush     (flush),
        .alloc     (alloc_w),
        .full      (full_w),
        .head      (head_w),
        .tail      (tail_w),
        .count     (occ)
    );

    rob_entry_store #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc          (alloc_w),
        .tail           (tail_w),
        .alloc_has_dest (issue_has_dest),
        .alloc_dest     (issue_dest),
        .cpl_valid      (cpl_valid),
        .cpl_tag        (cpl_tag),
        .cpl_data       (cpl_data),
        .cpl_flags      (cpl_flags),
        .retire         (retire_w),
        .flush          (flush),
        .head           (head_w),
        .rd_tag_a       (rd_tag_a),
        .rd_tag_b       (rd_tag_b),
        .head_vld       (head_vld),
        .head_has_dest  (head_hasd),
        .head_dest      (head_dest),
        .head_data      (head_data),
        .head_flags     (head_flags),
        .rd_vld_a       (rd_valid_a),
        .rd_data_a      (rd_data_a),
        .rd_vld_b       (rd_valid_b),
        .rd_data_b      (rd_data_b)
    );

    rob_commit_logic #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W),
        .KIND_MAP(KIND_MAP), .FORCE_MASK(FORCE_MASK)
    ) u_commit (
        .head_vld      (head_vld),
        .head_has_dest (head_hasd),
        .head_dest     (head_dest),
        .head_data     (head_data),
        .head_flags    (head_flags),
        .sr_mask       (sr_mask),
        .retire        (retire_w),
        .flush         (flush),
        .rf_we         (rf_we),
        .rf_addr       (rf_addr),
        .rf_data       (rf_data),
        .irq_valid     (irq_valid),
        .irq_kind      (irq_kind),
        .irq_flags     (irq_flags)
    );
endmodule

// File: rtl/rob_precise_commit_chk.sv
// Protocol checker for rob_precise_commit, attached by bind.
// Assumes occupancy and retire are the top's internal occ/retire_w nets.
module rob_precise_commit_chk #(
    parameter int DEPTH  = 8,
    parameter int FLAG_W = 4,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic [CNT_W-1:0]  occupancy,
    input logic              retire,
    input logic              flush,
    input logic              rf_we,
    input logic              irq_valid,
    input logic [1:0]        irq_kind,
    input logic [FLAG_W-1:0] irq_flags
);
    assert_ready_low_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CNT_W'(DEPTH)) |-> !issue_ready);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && !retire) |=> occupancy == $past(occupancy) + CNT_W'(1));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> occupancy == '0);

    assert_no_write_on_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rf_we);

    assert_irq_carries_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_flags != '0);

    assert_quiet_irq_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_flags == '0 && irq_kind == 2'b00));
endmodule

bind rob_precise_commit rob_precise_commit_chk #(.DEPTH(DEPTH), .FLAG_W(FLAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .occupancy   (occ),
    .retire      (retire_w),
    .flush       (flush),
    .rf_we       (rf_we),
    .irq_valid   (irq_valid),
    .irq_kind    (irq_kind),
    .irq_flags   (irq_flags)
);

// File: tb/rob_precise_commit_tb.sv
// Self-checking bench: a vector table of commit scenarios, then directed
// tests for reset, full buffer, out-of-order completion and flush.
module rob_precise_commit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_has_dest = 1'b0;
    logic [3:0]  issue_dest = '0;
    logic        issue_ready;
    logic [2:0]  issue_tag;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_tag = '0;
    logic [63:0] cpl_data = '0;
    logic [3:0]  cpl_flags = '0;
    logic [3:0]  sr_mask = '0;
    logic [2:0]  rd_tag_a = '0;
    logic        rd_valid_a;
    logic [63:0] rd_data_a;
    logic [2:0]  rd_tag_b = '0;
    logic        rd_valid_b;
    logic [63:0] rd_data_b;
    logic        rf_we;
    logic [3:0]  rf_addr;
    logic [63:0] rf_data;
    logic        irq_valid;
    logic [1:0]  irq_kind;
    logic [3:0]  irq_flags;
    logic        flush;

    int n_chk = 0;
    int n_bad = 0;
    int exp_head = 0;
    int exp_tail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_precise_commit dut_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_has_dest(issue_has_dest),
        .issue_dest(issue_dest), .issue_ready(issue_ready), .issue_tag(issue_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .cpl_flags(cpl_flags), .sr_mask(sr_mask),
        .rd_tag_a(rd_tag_a), .rd_valid_a(rd_valid_a), .rd_data_a(rd_data_a),
        .rd_tag_b(rd_tag_b), .rd_valid_b(rd_valid_b), .rd_data_b(rd_data_b),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .irq_valid(irq_valid), .irq_kind(irq_kind), .irq_flags(irq_flags),
        .flush(flush)
    );

    typedef struct packed {
        logic [3:0] flags;
        logic [3:0] mask;
        logic       hasd;
        logic [3:0] dest;
        logic       we;
        logic       irq;
        logic [1:0] kind;
        logic       fl;
    } vec_t;

    // Kinds: 00 continue, 01 repeat, 10 abort; flag0 abort (forced on), flag1 repeat, flags2/3 continue.
    localparam vec_t VECS [8] = '{
        '{4'b0000, 4'b1111, 1'b1, 4'd3,  1'b1, 1'b0, 2'b00, 1'b0},  // R5 clean
        '{4'b0100, 4'b0000, 1'b1, 4'd5,  1'b1, 1'b0, 2'b00, 1'b0},  // R7 masked off
        '{4'b0100, 4'b0100, 1'b1, 4'd6,  1'b1, 1'b1, 2'b00, 1'b0},  // R9 continue
        '{4'b0010, 4'b0010, 1'b1, 4'd7,  1'b0, 1'b1, 2'b01, 1'b1},  // R10 repeat
        '{4'b0001, 4'b0000, 1'b1, 4'd8,  1'b0, 1'b1, 2'b10, 1'b1},  // R7 forced abort
        '{4'b0110, 4'b0110, 1'b1, 4'd9,  1'b0, 1'b1, 2'b01, 1'b1},  // R8 priority
        '{4'b1100, 4'b1000, 1'b1, 4'd10, 1'b1, 1'b1, 2'b00, 1'b0},  // R8 masked lower
        '{4'b0000, 4'b0000, 1'b0, 4'd11, 1'b0, 1'b0, 2'b00, 1'b0}   // R6 no destination
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Allocate one slot; check the tag handed out.
    task automatic issue_one(input logic [3:0] d, input logic hd, output logic [2:0] tag);
        @(negedge clk);
        issue_valid = 1'b1; issue_dest = d; issue_has_dest = hd;
        #1;
        tag = issue_tag;
        chk("R2 issue tag", 64'(issue_tag), 64'(exp_tail));
        @(posedge clk);
        #1;
        issue_valid = 1'b0;
        exp_tail = (exp_tail + 1) % 8;
    endtask

    // Return a result; outputs reflecting it are valid on return.
    task automatic complete_one(input logic [2:0] t, input logic [63:0] d, input logic [3:0] f);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = t; cpl_data = d; cpl_flags = f;
        @(posedge clk);
        #1;
        cpl_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0]  tg;
        logic [2:0]  tags [8];
        logic [63:0] dv;

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1 reset state (also while reset is held)
        chk("R1 ready", 64'(issue_ready), 64'd1);
        chk("R1 tag", 64'(issue_tag), 64'd0);
        chk("R1 rf_we", 64'(rf_we), 64'd0);
        chk("R1 irq", 64'(irq_valid), 64'd0);
        chk("R1 flush", 64'(flush), 64'd0);
        rst_n = 1'b1;

        // Vector table: one slot per scenario through commit
        for (int v = 0; v < 8; v++) begin
            sr_mask = VECS[v].mask;
            dv = 64'hC0DE_0000_0000_0000 + 64'(v * 17);
            issue_one(VECS[v].dest, VECS[v].hasd, tg);
            complete_one(tg, dv, VECS[v].flags);
            chk("R5/R6 rf_we", 64'(rf_we), 64'(VECS[v].we));
            chk("R8 irq_valid", 64'(irq_valid), 64'(VECS[v].irq));
            chk("R8 irq_kind", 64'(irq_kind), 64'(VECS[v].kind));
            chk("R8 irq_flags", 64'(irq_flags),
                VECS[v].irq ? 64'(VECS[v].flags & (VECS[v].mask | 4'b0001)) : 64'd0);
            chk("R10 flush", 64'(flush), 64'(VECS[v].fl));
            if (VECS[v].we) begin
                chk("R9 rf_addr", 64'(rf_addr), 64'(VECS[v].dest));
                chk("R9 rf_data", rf_data, dv);
            end
            step();
            if (VECS[v].fl) exp_tail = exp_head;
            else exp_head = (exp_head + 1) % 8;
        end

        // R3: fill all eight slots
        sr_mask = 4'b0000;
        for (int k = 0; k < 8; k++) issue_one(4'(k), 1'b1, tags[k]);
        @(negedge clk);
        #1;
        chk("R3 full ready", 64'(issue_ready), 64'd0);
        issue_valid = 1'b1; issue_dest = 4'hF; issue_has_dest = 1'b1;
        step();
        issue_valid = 1'b0;
        chk("R3 tail held", 64'(issue_tag), 64'(exp_tail));
        chk("R3 still full", 64'(issue_ready), 64'd0);

        // R5/R11: younger completes first, head must wait
        complete_one(tags[2], 64'hAAAA_0002, 4'b0000);
        chk("R5 head waits", 64'(rf_we), 64'd0);
        rd_tag_a = tags[2]; rd_tag_b = tags[0];
        #1;
        chk("R11 port A valid", 64'(rd_valid_a), 64'd1);
        chk("R11 port A data", rd_data_a, 64'hAAAA_0002);
        chk("R11 port B invalid", 64'(rd_valid_b), 64'd0);
        complete_one(tags[0], 64'hAAAA_0000, 4'b0000);
        chk("R5 head commit", 64'(rf_we), 64'd1);
        chk("R5 head addr", 64'(rf_addr), 64'd0);
        chk("R5 head data", rf_data, 64'hAAAA_0000);
        step();
        exp_head = (exp_head + 1) % 8;
        chk("R5 next head idle", 64'(rf_we), 64'd0);
        chk("R3 space freed", 64'(issue_ready), 64'd1);
        complete_one(tags[1], 64'hAAAA_0001, 4'b0000);
        chk("R5 second addr", 64'(rf_addr), 64'd1);
        chk("R5 second we", 64'(rf_we), 64'd1);
        step();
        exp_head = (exp_head + 1) % 8;
        chk("R5 waiting one commits", 64'(rf_we), 64'd1);
        chk("R5 waiting addr", 64'(rf_addr), 64'd2);
        chk("R5 waiting data", rf_data, 64'hAAAA_0002);
        step();
        exp_head = (exp_head + 1) % 8;

        // R10: abort at head discards the rest
        complete_one(tags[4], 64'hBBBB_0004, 4'b0000);
        complete_one(tags[3], 64'hBBBB_0003, 4'b0001);
        chk("R10 flush high", 64'(flush), 64'd1);
        chk("R10 no write", 64'(rf_we), 64'd0);
        chk("R10 abort kind", 64'(irq_kind), 64'd2);
        step();
        exp_tail = exp_head;
        rd_tag_a = tags[4];
        #1;
        chk("R10 slot discarded", 64'(rd_valid_a), 64'd0);
        chk("R10 tail back", 64'(issue_tag), 64'(exp_head));
        chk("R10 ready", 64'(issue_ready), 64'd1);

        // R4: completion to a free slot is ignored
        tg = 3'((exp_tail + 3) % 8);
        complete_one(tg, 64'hDEAD, 4'b0000);
        rd_tag_b = tg;
        #1;
        chk("R4 free slot stays invalid", 64'(rd_valid_b), 64'd0);
        chk("R4 no commit", 64'(rf_we), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule